// File: doc/BRIEF.md
# Reduced-Precision Guarded FIR Filter

This block protects a small signed fixed-point low-pass filter against single-event upsets without tripling it. One full-width copy of a 5-tap symmetric FIR filter runs alongside two narrow copies. Each narrow copy sees the same sample stream with its low-order bits dropped. A decision stage compares the three results for each sample. When the full-width result moves further from the narrow estimate than a fault-free filter ever can, the decision stage substitutes the narrow estimate, rescaled to full width, and pulses an error flag.

Samples arrive with a valid strobe, and the filtered sample leaves two clock cycles later with its own strobe. The precision reduction and the error threshold are fixed when the design is elaborated. By default the threshold is the largest gap that truncation alone can create. A fault-injection port XORs a mask into the accumulator of a chosen copy for one sample. The bench uses it to emulate low-order and high-order upsets.

Top module: `rpr_fir_guard`

## Requirements
- R1: While reset is asserted and after its release until the first result, out_valid, err_flag and out_sample are all zero.
- R2: For each accepted sample the filter computes y = x[n] + 3x[n-1] + 4x[n-2] + 3x[n-3] + x[n-4]. Taps start at zero after reset. With no upset, y appears on out_sample with out_valid high exactly two clock edges after the edge that took in_valid.
- R3: With no injected fault, err_flag never rises, including for full-scale inputs (-2048 and 2047 with the default 12-bit sample width).
- R4: Each narrow copy filters floor(x / 16) (the default reduction is 4 bits), and its result is rescaled by 16. When both narrow copies agree and |full - rescaled| exceeds the threshold (default 180), out_sample carries the rescaled narrow result and err_flag is high for that one output.
- R5: When the narrow copies agree and |full - rescaled| is at most the threshold, the full-width result is output and err_flag stays low. A difference equal to the threshold does not switch the output.
- R6: An injection corrupts only the sample presented with it. The next sample is clean. A flip_target code of 3 selects no copy, and the mask then has no effect.
- R7: flip_target codes 1 and 2 upset narrow copy A and narrow copy B. If the two narrow copies disagree, the full-width result is output and err_flag stays low.
- R8: Cycles with in_valid low do not advance the filter taps and produce no output strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| flip_en | input | 1 | Apply the fault mask this cycle |
| flip_target | input | 2 | Copy to upset: 0 full, 1 narrow A, 2 narrow B, 3 none |
| flip_mask | input | DATA_W+4 | XOR mask for the target accumulator (low bits only for narrow copies) |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | DATA_W+4 | Signed filtered sample |
| err_flag | output | 1 | Full-width result replaced on this output |

## Verification
The bench pushes the threshold from both sides. With all-zero history it injects masks of 180 and 181. A comparison that is off by one, or that uses >= instead of >, then flags or forwards the wrong value. A high-order flip with live data must make the design forward the rescaled narrow value. A design that forwards the full-width value there, or rescales with the wrong shift, emits a corrupted sample. Upsets in a narrow copy must leave the full-width result in place, which catches a decision stage that trusts copy A alone. Full-scale sample runs and idle gaps show whether truncation error alone trips the flag and whether idle cycles shift the taps.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    localparam int NUM_TAPS  = 5;
    localparam int HALF_TAPS = (NUM_TAPS + 1) / 2;
    localparam int GROWTH    = 4;
    localparam int COEF_SUM  = 12;

    typedef enum logic [1:0] {
        HIT_FULL = 2'd0,
        HIT_NARA = 2'd1,
        HIT_NARB = 2'd2,
        HIT_NONE = 2'd3
    } hit_t;

    function automatic int coef(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/rpr_fir_lane.sv
module rpr_fir_lane #(
    parameter int IN_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic signed [IN_W-1:0]                in_sample,
    input  logic                                  flip_en,
    input  logic [IN_W+rpr_pkg::GROWTH-1:0]       flip_mask,
    output logic                                  out_valid,
    output logic signed [IN_W+rpr_pkg::GROWTH-1:0] out_acc
);
    localparam int ACC_W = IN_W + rpr_pkg::GROWTH;
    localparam int TAPS  = rpr_pkg::NUM_TAPS;
    localparam int HALF  = rpr_pkg::HALF_TAPS;

    typedef struct packed {
        logic [TAPS-1:0][IN_W-1:0] taps;
        logic [ACC_W-1:0]          acc;
        logic                      vld;
    } lane_t;

    lane_t st_q, st_d;

    function automatic logic signed [ACC_W-1:0] widen(input logic [IN_W-1:0] v);
        return {{rpr_pkg::GROWTH{v[IN_W-1]}}, v};
    endfunction

    always_comb begin
        logic [TAPS-1:0][IN_W-1:0] nt;
        logic signed [ACC_W-1:0]   sum_d;
        logic signed [ACC_W-1:0]   pair_d;
        st_d     = st_q;
        st_d.vld = in_valid;
        nt       = {st_q.taps[TAPS-2:0], in_sample};
        sum_d    = '0;
        for (int i = 0; i < HALF; i++) begin
            if (i == TAPS - 1 - i) pair_d = widen(nt[i]);
            else                   pair_d = widen(nt[i]) + widen(nt[TAPS-1-i]);
            sum_d = sum_d + pair_d * $signed(ACC_W'(rpr_pkg::coef(i)));
        end
        if (in_valid) begin
            st_d.taps = nt;
            st_d.acc  = sum_d;
        end
        if (flip_en) st_d.acc = st_d.acc ^ flip_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_acc   = $signed(st_q.acc);

    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flip_en) |=> ($stable(out_acc) && !out_valid));
endmodule

// File: rtl/rpr_vote.sv
module rpr_vote #(
    parameter int ACC_W  = 16,
    parameter int RED    = 4,
    parameter int THRESH = 180
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lanes_valid,
    input  logic signed [ACC_W-1:0]     full_acc,
    input  logic signed [ACC_W-RED-1:0] nar_a,
    input  logic signed [ACC_W-RED-1:0] nar_b,
    output logic                        out_valid,
    output logic signed [ACC_W-1:0]     out_sample,
    output logic                        err_flag
);
    localparam int DIFF_W = ACC_W + 1;
    localparam logic [DIFF_W-1:0] TH_V = DIFF_W'(THRESH);

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] data;
        logic             err;
    } vote_t;

    vote_t vt_q, vt_d;
    logic signed [ACC_W-1:0]  rescaled;
    logic signed [DIFF_W-1:0] gap;
    logic [DIFF_W-1:0]        gap_mag;
    logic                     agree, beyond;

    always_comb begin
        rescaled = {nar_a, {RED{1'b0}}};
        gap      = DIFF_W'(full_acc) - DIFF_W'(rescaled);
        gap_mag  = gap[DIFF_W-1] ? DIFF_W'(-gap) : DIFF_W'(gap);
        agree    = (nar_a == nar_b);
        beyond   = gap_mag > TH_V;
        vt_d     = vt_q;
        vt_d.vld = lanes_valid;
        vt_d.err = 1'b0;
        if (lanes_valid) begin
            if (agree && beyond) begin
                vt_d.data = rescaled;
                vt_d.err  = 1'b1;
            end else begin
                vt_d.data = full_acc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vt_q <= '0;
        else        vt_q <= vt_d;
    end

    assign out_valid  = vt_q.vld;
    assign out_sample = $signed(vt_q.data);
    assign err_flag   = vt_q.err;

    a_r4_flag_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> out_valid);
    a_r4_switch_to_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_valid && agree && beyond) |=> (err_flag && out_sample == $past(rescaled)));
    a_r5_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_valid && agree && !beyond) |=> (!err_flag && out_sample == $past(full_acc)));
    a_r7_disagree_full: assert property (@(posedge clk) disable iff (!rst_n)
        (lanes_valid && !agree) |=> (!err_flag && out_sample == $past(full_acc)));
endmodule

// File: rtl/rpr_fir_guard.sv
module rpr_fir_guard #(
    parameter int DATA_W   = 12,
    parameter int RED_BITS = 4,
    parameter int THRESH   = rpr_pkg::COEF_SUM * ((1 << RED_BITS) - 1)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      in_valid,
    input  logic signed [DATA_W-1:0]                  in_sample,
    input  logic                                      flip_en,
    input  logic [1:0]                                flip_target,
    input  logic [DATA_W+rpr_pkg::GROWTH-1:0]         flip_mask,
    output logic                                      out_valid,
    output logic signed [DATA_W+rpr_pkg::GROWTH-1:0]  out_sample,
    output logic                                      err_flag
);
    localparam int ACC_W  = DATA_W + rpr_pkg::GROWTH;
    localparam int NIN_W  = DATA_W - RED_BITS;
    localparam int NACC_W = NIN_W + rpr_pkg::GROWTH;

    logic                     full_v;
    logic signed [ACC_W-1:0]  full_acc;
    logic [1:0]               nar_v;
    logic signed [NACC_W-1:0] nar_acc [2];

    rpr_fir_lane #(.IN_W(DATA_W)) u_full (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sample(in_sample),
        .flip_en(flip_en && flip_target == rpr_pkg::HIT_FULL),
        .flip_mask(flip_mask),
        .out_valid(full_v), .out_acc(full_acc)
    );

    for (genvar g = 0; g < 2; g++) begin : g_narrow
        rpr_fir_lane #(.IN_W(NIN_W)) u_nar (
            .clk(clk), .rst_n(rst_n),
            .in_valid(in_valid), .in_sample(in_sample[DATA_W-1:RED_BITS]),
            .flip_en(flip_en && flip_target == 2'(g + 1)),
            .flip_mask(flip_mask[NACC_W-1:0]),
            .out_valid(nar_v[g]), .out_acc(nar_acc[g])
        );
    end

    rpr_vote #(.ACC_W(ACC_W), .RED(RED_BITS), .THRESH(THRESH)) u_vote (
        .clk(clk), .rst_n(rst_n),
        .lanes_valid(full_v & nar_v[0] & nar_v[1]),
        .full_acc(full_acc), .nar_a(nar_acc[0]), .nar_b(nar_acc[1]),
        .out_valid(out_valid), .out_sample(out_sample), .err_flag(err_flag)
    );

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !err_flag && out_sample == '0));
    a_r6_one_shot_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flip_en) |=> ##1 !err_flag);
endmodule

// File: tb/rpr_fir_guard_bench.sv
module rpr_fir_guard_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [11:0] in_sample = '0;
    logic flip_en = 1'b0;
    logic [1:0] flip_target = 2'd3;
    logic [15:0] flip_mask = '0;
    logic out_valid, err_flag;
    logic signed [15:0] out_sample;

    int checks = 0;
    int errors = 0;
    string tag = "R1";
    bit finished = 0;

    int hist [5];
    bit s1_v, exp_v;
    logic signed [15:0] s1_d, exp_d;
    bit s1_e, exp_e;
    int prng = 7;
    int flags_seen = 0;

    always #4 clk = ~clk;

    rpr_fir_guard u_rpr_fir_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .flip_en(flip_en), .flip_target(flip_target), .flip_mask(flip_mask),
        .out_valid(out_valid), .out_sample(out_sample), .err_flag(err_flag)
    );

    function automatic int wsum(input int h [5], input int sh);
        int c [5] = '{1, 3, 4, 3, 1};
        int s = 0;
        for (int i = 0; i < 5; i++) s += c[i] * (h[i] >>> sh);
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) hist[i] = 0;
            s1_v = 0; s1_d = '0; s1_e = 0;
            exp_v = 0; exp_d = '0; exp_e = 0;
        end else begin
            logic signed [15:0] fp, sc;
            logic signed [11:0] na, nb;
            int gap;
            exp_v = s1_v;
            exp_e = s1_e;
            if (s1_v) exp_d = s1_d;
            s1_v = in_valid;
            s1_e = 0;
            if (in_valid) begin
                for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'(in_sample);
                fp = 16'(wsum(hist, 0));
                na = 12'(wsum(hist, 4));
                nb = na;
                if (flip_en && flip_target == 2'd0) fp = fp ^ flip_mask;
                if (flip_en && flip_target == 2'd1) na = na ^ flip_mask[11:0];
                if (flip_en && flip_target == 2'd2) nb = nb ^ flip_mask[11:0];
                sc  = 16'(int'(na) * 16);
                gap = int'(fp) - int'(sc);
                if (gap < 0) gap = -gap;
                if (na == nb && gap > 180) begin
                    s1_d = sc; s1_e = 1;
                end else begin
                    s1_d = fp;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (out_valid !== exp_v || err_flag !== exp_e || out_sample !== exp_d) begin
                errors++;
                $display("FAIL %s: got v=%0b d=%0d e=%0b, expected v=%0b d=%0d e=%0b",
                         tag, out_valid, out_sample, err_flag, exp_v, exp_d, exp_e);
            end
            if (err_flag === 1'b1) flags_seen++;
        end
    end

    task automatic send(input int x, input bit fe, input logic [1:0] tg, input logic [15:0] m);
        @(negedge clk); #1;
        in_valid = 1'b1; in_sample = 12'(x);
        flip_en = fe; flip_target = tg; flip_mask = m;
        @(negedge clk); #1;
        in_valid = 1'b0; flip_en = 1'b0; flip_target = 2'd3; flip_mask = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int next_rand();
        prng = prng * 1103515245 + 12345;
        return int'($signed(12'(prng >>> 16)));
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tag = "R1";
        idle(4);
        @(negedge clk); #1; rst_n = 1'b1;
        idle(2);
        tag = "R2";
        send(1000, 0, 2'd3, 16'h0);
        for (int i = 0; i < 5; i++) send(0, 0, 2'd3, 16'h0);
        for (int i = 0; i < 40; i++) send(next_rand(), 0, 2'd3, 16'h0);
        tag = "R3";
        for (int i = 0; i < 6; i++) send(2047, 0, 2'd3, 16'h0);
        for (int i = 0; i < 6; i++) send(-2048, 0, 2'd3, 16'h0);
        for (int i = 0; i < 10; i++) send((i % 2) ? 2047 : -2033, 0, 2'd3, 16'h0);
        tag = "R8";
        for (int i = 0; i < 10; i++) begin
            send(next_rand(), 0, 2'd3, 16'h0);
            idle(i % 3);
        end
        tag = "R4";
        send(300, 0, 2'd3, 16'h0);
        send(-700, 1, 2'd0, 16'h8000);
        tag = "R6";
        send(55, 0, 2'd3, 16'h0);
        send(1200, 1, 2'd3, 16'hFFFF);
        tag = "R4";
        send(-1500, 1, 2'd0, 16'h1000);
        tag = "R5";
        for (int i = 0; i < 5; i++) send(0, 0, 2'd3, 16'h0);
        send(0, 1, 2'd0, 16'd180);
        tag = "R4";
        send(0, 1, 2'd0, 16'd181);
        tag = "R5";
        send(16, 1, 2'd0, 16'h0001);
        tag = "R7";
        send(400, 1, 2'd1, 16'h0800);
        send(-400, 1, 2'd2, 16'h0400);
        send(900, 1, 2'd1, 16'h0001);
        tag = "R6";
        for (int i = 0; i < 6; i++) send(next_rand(), 0, 2'd3, 16'h0);
        idle(3);
        checks++;
        if (flags_seen < 3) begin
            errors++;
            $display("FAIL R4: got %0d flagged outputs, expected at least 3", flags_seen);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule